// File: doc/BRIEF.md
# SD Card Clock Divider and Gate

This block derives the clock sent to an SD card from the host clock. A control register selects a power-of-two division ratio through a one-hot code and holds a clock enable. A second register carries a global run/stop control. The card clock toggles only while both the enable and the run control are set. Otherwise it rests low.

Changes to the divider and stop requests are applied only at phase boundaries of the card clock, so the card never sees a shortened pulse. A status bit, also driven on a dedicated output, tells software whether the card clock is actually running. Software raises the enable before setting run. When shutting down, it clears run first and only then drops the enable.

The two registers are reached through a single-cycle write strobe, a register select and a combinational read-back bus.

Top module: `sdcard_clkgen`

## Requirements
- R1: After reset the card clock is low, the running output is 0, the control register reads 0x0080 and the run register reads 0x0000.
- R2: Control register (select 0) layout: bits 7:0 hold the divider code and bit 8 holds the clock enable. Bits 15:9 ignore writes and read 0, so writing 0xFFFF reads back 0x01FF.
- R3: Run register (select 1) layout: bit 8 is the writable run control and bit 0 is a read-only copy of the running status. All other bits read 0.
- R4: The card clock toggles only while both the enable (control bit 8) and run (run bit 8) are 1. With either one cleared it stays low.
- R5: A divider code whose lowest set bit is k makes each card-clock phase 2^(k+1) host cycles long. Code 0x80 therefore divides by 512, and each lower bit halves the period.
- R6: Divider code 0x00 gives the fastest clock: one host cycle high, one host cycle low.
- R7: A divider code with several bits set behaves as its lowest set bit alone.
- R8: A new divider code takes effect at the start of the next low phase. A phase already under way, and the high phase that follows a low phase in progress, keep the old length.
- R9: A stop request that arrives during a high phase lets that phase complete at full length, then holds the clock low. A stop request that arrives during a low phase holds the clock low at once.
- R10: The running output and status bit read 1 while the card clock toggles. They read 0 once the clock has been brought to rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | Register select: 0 control, 1 run/status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read-back of the selected register |
| card_clk | output | 1 | Divided and gated card clock |
| clk_running | output | 1 | 1 while the card clock is toggling |

## Verification
The hardest situations to reach are the phase-boundary cases. These are a divider rewrite or a stop request that lands part-way through a high phase or part-way through a low phase.

The bench first locks onto a card-clock rising edge by sampling between host edges. It then issues the register write a fixed number of cycles into the chosen phase. Finally it measures the lengths of the remaining and following phases in host cycles, which shows whether the old length was kept and when the new one began.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int REG_W        = 16;
    localparam int DIV_W_DEF    = 8;
    localparam int RUN_BIT      = 8;
    localparam int STAT_BIT     = 0;
    localparam logic [7:0] DIV_RESET = 8'h80;
endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
    import sdclk_pkg::*;
#(
    parameter int DIV_BITS = DIV_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_sel,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic                running,
    output logic [REG_W-1:0]    reg_rdata,
    output logic [DIV_BITS-1:0] div_code,
    output logic                gate
);
    localparam int EN_POS = DIV_BITS;

    typedef struct packed {
        logic                en;
        logic [DIV_BITS-1:0] div;
        logic                run;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        if (reg_wr) begin
            if (!reg_sel) begin
                d.div = reg_wdata[DIV_BITS-1:0];
                d.en  = reg_wdata[EN_POS];
            end else begin
                d.run = reg_wdata[RUN_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.en  <= 1'b0;
            q.div <= DIV_RESET[DIV_BITS-1:0];
            q.run <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_sel) begin
            reg_rdata[DIV_BITS-1:0] = q.div;
            reg_rdata[EN_POS]       = q.en;
        end else begin
            reg_rdata[RUN_BIT]  = q.run;
            reg_rdata[STAT_BIT] = running;
        end
    end

    assign div_code = q.div;
    assign gate     = q.en & q.run;

    // R2 / R3: unused bits never read back as 1
    assert_rdata_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:RUN_BIT+1] == '0);

    // R2: a control write lands in the enable field on the next cycle
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel) |=> (gate == ($past(reg_wdata[EN_POS]) & q.run)));
endmodule

// File: rtl/sdclk_divsel.sv
module sdclk_divsel #(
    parameter int DIV_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_BITS-1:0] code,
    output logic [DIV_BITS-1:0] half_m1
);
    logic [DIV_BITS:0]   seen;
    logic [DIV_BITS-1:0] pick;

    assign seen[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < DIV_BITS; k++) begin : g_prio
            assign pick[k]   = code[k] & ~seen[k];
            assign seen[k+1] = seen[k] | code[k];
        end
    endgenerate

    // phase length for bit k is 2^(k+1); store length minus one
    always_comb begin
        half_m1 = '0;
        for (int i = 0; i < DIV_BITS; i++) begin
            if (pick[i]) half_m1 = DIV_BITS'((1 << (i + 1)) - 1);
        end
    end

    // R7: at most one divider bit is honoured
    assert_single_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick));
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
    parameter int DIV_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gate,
    input  logic [DIV_BITS-1:0] new_half_m1,
    output logic                card_clk,
    output logic                running
);
    typedef struct packed {
        logic                clk;
        logic                run;
        logic [DIV_BITS-1:0] cnt;
        logic [DIV_BITS-1:0] hm1;
    } gen_t;

    gen_t d, q;

    always_comb begin
        d = q;
        if (!q.run) begin
            d.clk = 1'b0;
            d.cnt = '0;
            d.hm1 = new_half_m1;
            if (gate) d.run = 1'b1;
        end else if (!q.clk) begin
            if (!gate) begin
                d.run = 1'b0;
                d.cnt = '0;
                d.hm1 = new_half_m1;
            end else if (q.cnt == q.hm1) begin
                d.clk = 1'b1;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            if (q.cnt == q.hm1) begin
                d.clk = 1'b0;
                d.cnt = '0;
                d.hm1 = new_half_m1;
                d.run = gate;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign card_clk = q.clk;
    assign running  = q.run;

    // R4: a rising card edge needs both controls set the cycle before
    assert_rise_needs_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.clk) |-> ($past(gate) && $past(q.run)));

    // R8: the phase length never changes inside a high phase
    assert_hold_ratio_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.clk && $past(q.clk)) |-> $stable(q.hm1));

    // R5: the phase counter stays within the active phase length
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |-> (q.cnt <= q.hm1));

    // R9 / R10: a high clock is always reported as running
    assert_high_is_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.clk |-> q.run);
endmodule

// File: rtl/sdcard_clkgen.sv
module sdcard_clkgen
    import sdclk_pkg::*;
#(
    parameter int DIV_BITS = DIV_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              card_clk,
    output logic              clk_running
);
    logic [DIV_BITS-1:0] div_code;
    logic [DIV_BITS-1:0] half_m1;
    logic                gate;
    logic                running;

    sdclk_regs #(.DIV_BITS(DIV_BITS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .running   (running),
        .reg_rdata (reg_rdata),
        .div_code  (div_code),
        .gate      (gate)
    );

    sdclk_divsel #(.DIV_BITS(DIV_BITS)) u_divsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .code    (div_code),
        .half_m1 (half_m1)
    );

    sdclk_gen #(.DIV_BITS(DIV_BITS)) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate        (gate),
        .new_half_m1 (half_m1),
        .card_clk    (card_clk),
        .running     (running)
    );

    assign clk_running = running;
endmodule

// File: tb/sdcard_clkgen_test.sv
module sdcard_clkgen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        card_clk;
    logic        clk_running;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    sdcard_clkgen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .card_clk    (card_clk),
        .clk_running (clk_running)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [15:0] data);
        reg_sel   = sel;
        reg_wdata = data;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input bit sel, output logic [15:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_rise(input string req);
        bit prev;
        bit found;
        prev  = card_clk;
        found = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (card_clk && !prev) begin
                found = 1'b1;
                break;
            end
            prev = card_clk;
        end
        if (!found) chk(1'b0, req, 0, 1);
    endtask

    task automatic measure(input bit level, output int n);
        n = 0;
        while (card_clk == level && n < 3000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_highs(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (card_clk) n++;
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk(card_clk == 1'b0, "R1 card_clk", card_clk, 0);
        chk(clk_running == 1'b0, "R1 running", clk_running, 0);
        rd(1'b0, v);
        chk(v == 16'h0080, "R1 ctrl reset", v, 16'h0080);
        rd(1'b1, v);
        chk(v == 16'h0000, "R1 run reset", v, 0);
    endtask

    task automatic t_layout();
        logic [15:0] v;
        wr(1'b0, 16'hFFFF);
        rd(1'b0, v);
        chk(v == 16'h01FF, "R2 ctrl mask", v, 16'h01FF);
        wr(1'b0, 16'h0080);
        wr(1'b1, 16'hFFFF);
        rd(1'b1, v);
        chk(v == 16'h0100, "R3 run mask", v, 16'h0100);
        wr(1'b1, 16'h0000);
        rd(1'b1, v);
        chk(v == 16'h0000, "R3 run cleared", v, 0);
    endtask

    task automatic t_one_enable();
        int n;
        wr(1'b0, 16'h0101);
        count_highs(200, n);
        chk(n == 0, "R4 enable only", n, 0);
        chk(clk_running == 1'b0, "R4 enable only running", clk_running, 0);
        wr(1'b0, 16'h0001);
        wr(1'b1, 16'h0100);
        count_highs(200, n);
        chk(n == 0, "R4 run only", n, 0);
        wr(1'b1, 16'h0000);
    endtask

    task automatic t_period(input logic [7:0] code, input int half, input string req);
        int h;
        int l;
        logic [15:0] v;
        wr(1'b0, {8'h01, code});
        wr(1'b1, 16'h0100);
        wait_rise(req);
        measure(1'b1, h);
        measure(1'b0, l);
        chk(h == half, {req, " high phase"}, h, half);
        chk(l == half, {req, " low phase"}, l, half);
        rd(1'b1, v);
        chk(v == 16'h0101, "R10 status bit while running", v, 16'h0101);
        chk(clk_running == 1'b1, "R10 running port", clk_running, 1);
        wr(1'b1, 16'h0000);
        repeat (2 * half + 8) @(negedge clk);
        chk(card_clk == 1'b0, {req, " rest low"}, card_clk, 0);
        chk(clk_running == 1'b0, "R10 running cleared", clk_running, 0);
    endtask

    task automatic t_stop_high();
        int h;
        int n;
        wr(1'b0, 16'h0110);
        wr(1'b1, 16'h0100);
        wait_rise("R9 stop high");
        wr(1'b1, 16'h0000);
        measure(1'b1, h);
        chk(h + 1 == 32, "R9 high phase completed", h + 1, 32);
        count_highs(100, n);
        chk(n == 0, "R9 held low after stop", n, 0);
        chk(clk_running == 1'b0, "R10 stopped status", clk_running, 0);
    endtask

    task automatic t_stop_low();
        int h;
        int n;
        wr(1'b1, 16'h0100);
        wait_rise("R9 stop low");
        measure(1'b1, h);
        wr(1'b1, 16'h0000);
        count_highs(100, n);
        chk(n == 0, "R9 stop during low", n, 0);
        chk(clk_running == 1'b0, "R9 stop low running", clk_running, 0);
    endtask

    task automatic t_change_high();
        int h;
        int l;
        wr(1'b0, 16'h0110);
        wr(1'b1, 16'h0100);
        wait_rise("R8 change high");
        wr(1'b0, 16'h0101);
        measure(1'b1, h);
        chk(h + 1 == 32, "R8 high keeps old length", h + 1, 32);
        measure(1'b0, l);
        chk(l == 2, "R8 next low uses new length", l, 2);
        measure(1'b1, h);
        chk(h == 2, "R8 following high new length", h, 2);
        wr(1'b1, 16'h0000);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_change_low();
        int h;
        int l;
        wr(1'b0, 16'h0110);
        wr(1'b1, 16'h0100);
        wait_rise("R8 change low");
        measure(1'b1, h);
        wr(1'b0, 16'h0102);
        measure(1'b0, l);
        chk(l + 1 == 32, "R8 low keeps old length", l + 1, 32);
        measure(1'b1, h);
        chk(h == 32, "R8 high after keeps old length", h, 32);
        measure(1'b0, l);
        chk(l == 4, "R8 new length after next fall", l, 4);
        wr(1'b1, 16'h0000);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_one_enable();
        t_period(8'h80, 256, "R5 code 0x80");
        t_period(8'h01, 2, "R5 code 0x01");
        t_period(8'h04, 8, "R5 code 0x04");
        t_period(8'h00, 1, "R6 code 0x00");
        t_period(8'h0C, 8, "R7 code 0x0C");
        t_period(8'hA0, 64, "R7 code 0xA0");
        t_stop_high();
        t_stop_low();
        t_change_high();
        t_change_low();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule